// File: doc/BRIEF.md
# Byte-Wide Non-Volatile Data Store Controller

This block gives a processor access to a 64-byte non-volatile data store through four registers on a simple register bus. Software reaches the store through a control/status register, a data register and an address register. Every write cycle must first be unlocked through a key register that holds no state. A read is a one-cycle operation: software sets a start bit, and the addressed byte is loaded into the data register. A write is a timed operation. It first erases the target byte to all ones and then programs the new value. The cycle length comes from an internal counter and not from the bus.

Two finite-state machines drive the block. The sequencer has the states SEQ_IDLE, SEQ_READ, SEQ_ERASE and SEQ_PROG. Its transitions are:
- IDLE to READ on a read start.
- READ to IDLE after one cycle.
- IDLE to ERASE on an unlocked write start.
- ERASE to PROG when the erase count expires.
- PROG to IDLE when the program count expires.
- ERASE or PROG to IDLE on a warm reset, which is an abort.

The key machine has the states KEY_LOCKED, KEY_FIRST and KEY_ARMED. Its transitions are:
- LOCKED to FIRST when the first key is written.
- FIRST to ARMED when the second key is written.
- Any other bus write sends FIRST back to LOCKED.
- Any bus write sends ARMED back to LOCKED.
- A warm reset forces LOCKED.

The block has two reset inputs. `por_n` is the power-on reset; it clears every register and fills the store with 0xFF. `warm_n` is the warm reset. It aborts a write in progress and records the abort in a sticky error bit. The data register, the address register and the store all keep their contents through a warm reset.

Top module: `nvbyte_ctrl`

## Requirements
- R1: After power-on reset the control, data and address registers read 0x00, and every byte of the store reads 0xFF.
- R2: `bus_sel` picks the register: 0 is control, 1 is data, 2 is address, 3 is key. The control register bits are: bit 4 done, bit 3 error, bit 2 write enable, bit 1 write busy/start, bit 0 read busy/start. Bits 7..5 of the control register always read 0, and the key register always reads 0.
- R3: Writing control with bit 0 set while idle makes bit 0 read 1 for exactly one cycle. After that cycle the data register holds the byte at address register bits 5..0, and address bits 7..6 are ignored.
- R4: Software cannot clear bit 1 or bit 0 of the control register. Writing 0 to either bit while the operation is running leaves it set.
- R5: A write cycle starts only under these conditions:
  - Three consecutive bus writes are made: 0x55 to the key register, then 0xAA to the key register, then a control write with bits 2 and 1 set.
  - Write enable is already 1 at each of these three writes.
  - If any other bus write breaks the sequence, the start has no effect and the store is unchanged.
- R6: With write enable at 0, the key writes are rejected. A control write with bit 2 clear never starts a cycle.
- R7: Control bit 1 reads 1 for exactly ERASE_CYC+PROG_CYC cycles after the start write.
- R8: When a write finishes, the done bit is set, the error bit stays 0, and the byte holds the new value. The done bit stays set until software writes 0 to it.
- R9: A warm reset during a write does the following:
  - It sets the error bit and clears write enable and control bits 1 and 0.
  - If the abort falls in the erase phase, the byte is left unchanged.
  - If the abort falls in the program phase, the byte is left at 0xFF.
- R10: While a write runs, read starts are ignored. Software may change the address and data registers, but the address and data captured at the start are the ones written to the store.
- R11: A warm reset with no write running leaves the error bit at 0. It also preserves the data register, the address register and the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| warm_n | input | 1 | Warm reset, active low, synchronous; aborts a running write |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_sel | input | 2 | Register select (0 control, 1 data, 2 address, 3 key) |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_sel`, combinational |

## Verification
The bench goes after the following corner cases:
- **Broken key sequence.** An ordinary data write placed between the two keys must not leave the controller armed. A design that keeps the key state across other writes would program the byte.
- **Abort phase.** Warm resets are placed in both the erase phase and the program phase. A design that erases too early or programs too late would leave the wrong byte value behind.
- **Busy window.** Bit 1 is sampled one cycle before and exactly at the end of the write. An off-by-one counter would miss this window.
- **Captured operands.** The address and data registers are rewritten during a write. A design that programs from the live registers instead of the captured copies would hit the wrong location.
- **Software clearing start bits.** Bit 1 is written to 0 during a busy cycle. A design that lets software clear it would end the cycle early.
- **Upper address bits.** An address with bits 7..6 set is used. A design that indexes with the full register would read the wrong byte.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_ERASE = 2'd2,
        SEQ_PROG  = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        KEY_LOCKED = 2'd0,
        KEY_FIRST  = 2'd1,
        KEY_ARMED  = 2'd2
    } key_state_t;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_DATA = 2'd1;
    localparam logic [1:0] SEL_ADDR = 2'd2;
    localparam logic [1:0] SEL_KEY  = 2'd3;

    localparam int CB_RD   = 0;
    localparam int CB_WR   = 1;
    localparam int CB_WREN = 2;
    localparam int CB_ERR  = 3;
    localparam int CB_DONE = 4;

    localparam logic [7:0] KEY_ONE  = 8'h55;
    localparam logic [7:0] KEY_TWO  = 8'hAA;
    localparam logic [7:0] ERASED_B = 8'hFF;

endpackage

// File: rtl/nvb_array.sv
module nvb_array
    import nvb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] cell_q [DEPTH];

    // Power-on fills the store with the erased pattern.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cell_q[i] <= DW'(ERASED_B);
            end
        end else if (we) begin
            cell_q[waddr] <= wdata;
        end
    end

    assign rdata = cell_q[raddr];

endmodule

// File: rtl/nvb_unlock.sv
module nvb_unlock
    import nvb_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       warm_n,
    input  logic       wr_stb,
    input  logic [1:0] sel,
    input  logic [7:0] wdata,
    input  logic       wren,
    output logic       armed
);

    key_state_t state_q, state_d;
    logic       key_wr;

    assign key_wr = wr_stb && (sel == SEL_KEY) && wren;

    always_ff @(posedge clk) begin
        if (!por_n || !warm_n) begin
            state_q <= KEY_LOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        if (wr_stb) begin
            unique case (state_q)
                KEY_LOCKED: state_d = (key_wr && wdata == KEY_ONE) ? KEY_FIRST : KEY_LOCKED;
                KEY_FIRST:  state_d = (key_wr && wdata == KEY_TWO) ? KEY_ARMED : KEY_LOCKED;
                KEY_ARMED:  state_d = KEY_LOCKED;
                default:    state_d = KEY_LOCKED;
            endcase
        end
    end

    assign armed = (state_q == KEY_ARMED);

endmodule

// File: rtl/nvb_seq.sv
module nvb_seq
    import nvb_pkg::*;
#(
    parameter int AW        = 6,
    parameter int DW        = 8,
    parameter int ERASE_CYC = 8,
    parameter int PROG_CYC  = 8
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          warm_n,
    input  logic          rd_go,
    input  logic          wr_go,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output seq_state_t    state_o,
    output logic          arr_we,
    output logic [AW-1:0] arr_addr,
    output logic [DW-1:0] arr_wdata,
    output logic          data_ld,
    output logic          done_set,
    output logic          abort
);

    localparam int MAXC = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] E_LAST = CW'(ERASE_CYC - 1);
    localparam logic [CW-1:0] P_LAST = CW'(PROG_CYC - 1);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          e_end, p_end, busy_wr;

    assign e_end   = (state_q == SEQ_ERASE) && (cnt_q == E_LAST);
    assign p_end   = (state_q == SEQ_PROG)  && (cnt_q == P_LAST);
    assign busy_wr = (state_q == SEQ_ERASE) || (state_q == SEQ_PROG);

    // State register.
    always_ff @(posedge clk) begin
        if (!por_n || !warm_n) begin
            state_q <= SEQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Operands captured at the start of an operation.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (warm_n && state_q == SEQ_IDLE) begin
            if (rd_go || wr_go) addr_q <= addr_in;
            if (wr_go)          data_q <= data_in;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            SEQ_IDLE: begin
                cnt_d = '0;
                if (wr_go)      state_d = SEQ_ERASE;
                else if (rd_go) state_d = SEQ_READ;
            end
            SEQ_READ: state_d = SEQ_IDLE;
            SEQ_ERASE: begin
                if (e_end) begin
                    state_d = SEQ_PROG;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            SEQ_PROG: begin
                if (p_end) begin
                    state_d = SEQ_IDLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = SEQ_IDLE;
        endcase
    end

    // Output logic.
    always_comb begin
        state_o   = state_q;
        arr_addr  = addr_q;
        arr_we    = warm_n && (e_end || p_end);
        arr_wdata = (state_q == SEQ_ERASE) ? DW'(ERASED_B) : data_q;
        data_ld   = warm_n && (state_q == SEQ_READ);
        done_set  = warm_n && p_end;
        abort     = !warm_n && busy_wr;
    end

endmodule

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl
    import nvb_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int ERASE_CYC = 8,
    parameter int PROG_CYC  = 8
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       warm_n,
    input  logic       bus_wr,
    input  logic [1:0] bus_sel,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);

    localparam int DW = 8;
    localparam int AW = $clog2(DEPTH);

    logic [DW-1:0] data_q, addr_q, arr_rdata, arr_wdata;
    logic [AW-1:0] arr_addr;
    logic          wren_q, done_q, err_q;
    logic          armed, idle, ctrl_wr, rd_go, wr_go;
    logic          arr_we, data_ld, done_set, abort;
    logic          rd_busy, wr_busy;
    seq_state_t    seq_state;

    assign idle    = (seq_state == SEQ_IDLE);
    assign ctrl_wr = warm_n && bus_wr && (bus_sel == SEL_CTRL);
    assign wr_go   = ctrl_wr && idle && armed && wren_q
                     && bus_wdata[CB_WR] && bus_wdata[CB_WREN];
    assign rd_go   = ctrl_wr && idle && !wr_go && bus_wdata[CB_RD];
    assign rd_busy = (seq_state == SEQ_READ);
    assign wr_busy = (seq_state == SEQ_ERASE) || (seq_state == SEQ_PROG);

    nvb_unlock u_key (
        .clk    (clk),
        .por_n  (por_n),
        .warm_n (warm_n),
        .wr_stb (bus_wr),
        .sel    (bus_sel),
        .wdata  (bus_wdata),
        .wren   (wren_q),
        .armed  (armed)
    );

    nvb_seq #(
        .AW        (AW),
        .DW        (DW),
        .ERASE_CYC (ERASE_CYC),
        .PROG_CYC  (PROG_CYC)
    ) u_seq (
        .clk       (clk),
        .por_n     (por_n),
        .warm_n    (warm_n),
        .rd_go     (rd_go),
        .wr_go     (wr_go),
        .addr_in   (addr_q[AW-1:0]),
        .data_in   (data_q),
        .state_o   (seq_state),
        .arr_we    (arr_we),
        .arr_addr  (arr_addr),
        .arr_wdata (arr_wdata),
        .data_ld   (data_ld),
        .done_set  (done_set),
        .abort     (abort)
    );

    nvb_array #(
        .DEPTH (DEPTH),
        .DW    (DW)
    ) u_store (
        .clk   (clk),
        .por_n (por_n),
        .we    (arr_we),
        .waddr (arr_addr),
        .wdata (arr_wdata),
        .raddr (arr_addr),
        .rdata (arr_rdata)
    );

    // Control and status bits.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            wren_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else if (!warm_n) begin
            wren_q <= 1'b0;
            err_q  <= err_q | abort;
        end else if (ctrl_wr) begin
            wren_q <= bus_wdata[CB_WREN];
            done_q <= bus_wdata[CB_DONE] | done_set;
            err_q  <= bus_wdata[CB_ERR];
        end else if (done_set) begin
            done_q <= 1'b1;
        end
    end

    // Data and address registers.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            data_q <= '0;
            addr_q <= '0;
        end else if (warm_n) begin
            if (data_ld) begin
                data_q <= arr_rdata;
            end else if (bus_wr && bus_sel == SEL_DATA) begin
                data_q <= bus_wdata;
            end
            if (bus_wr && bus_sel == SEL_ADDR) begin
                addr_q <= bus_wdata;
            end
        end
    end

    always_comb begin
        unique case (bus_sel)
            SEL_CTRL: bus_rdata = {3'b000, done_q, err_q, wren_q, wr_busy, rd_busy};
            SEL_DATA: bus_rdata = data_q;
            SEL_ADDR: bus_rdata = addr_q;
            SEL_KEY:  bus_rdata = 8'h00;
            default:  bus_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/nvb_checker.sv
module nvb_checker (
    input logic       clk,
    input logic       por_n,
    input logic       warm_n,
    input logic [1:0] bus_sel,
    input logic [7:0] bus_rdata,
    input logic       wren,
    input logic       rd_bit,
    input logic       wr_bit,
    input logic       done,
    input logic       err,
    input logic       abort
);

    p_key_reads_zero_r2: assert property (@(posedge clk) disable iff (!por_n)
        (bus_sel == 2'd3) |-> (bus_rdata == 8'h00));

    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!por_n)
        (bus_sel == 2'd0) |-> (bus_rdata[7:5] == 3'b000));

    p_read_one_cycle_r3: assert property (@(posedge clk) disable iff (!por_n)
        rd_bit |=> !rd_bit);

    p_start_needs_enable_r6: assert property (@(posedge clk) disable iff (!por_n)
        $rose(wr_bit) |-> $past(wren));

    p_done_on_finish_r8: assert property (@(posedge clk) disable iff (!por_n)
        ($fell(wr_bit) && !$past(abort)) |-> done);

    p_abort_sets_err_r9: assert property (@(posedge clk) disable iff (!por_n)
        abort |=> err);

    p_warm_clears_r9: assert property (@(posedge clk) disable iff (!por_n)
        !warm_n |=> (!wren && !wr_bit && !rd_bit));

    p_no_read_in_write_r10: assert property (@(posedge clk) disable iff (!por_n)
        !(rd_bit && wr_bit));

endmodule

bind nvbyte_ctrl nvb_checker u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .warm_n    (warm_n),
    .bus_sel   (bus_sel),
    .bus_rdata (bus_rdata),
    .wren      (wren_q),
    .rd_bit    (rd_busy),
    .wr_bit    (wr_busy),
    .done      (done_q),
    .err       (err_q),
    .abort     (abort)
);

// File: tb/tb_nvbyte_ctrl.sv
module tb_nvbyte_ctrl;

    localparam int ERASE_CYC = 8;
    localparam int PROG_CYC  = 8;

    localparam logic [1:0] OP_W = 2'd0;  // bus write
    localparam logic [1:0] OP_C = 2'd1;  // check read data
    localparam logic [1:0] OP_T = 2'd2;  // wait cycles
    localparam logic [1:0] OP_X = 2'd3;  // warm reset pulse
    localparam logic [1:0] CT = 2'd0, DA = 2'd1, AD = 2'd2, KY = 2'd3;

    localparam int NV = 103;
    // {op, sel, requirement, value}
    localparam logic [15:0] VEC [NV] = '{
        {OP_C, CT, 4'd1, 8'h00}, {OP_C, DA, 4'd1, 8'h00}, {OP_C, AD, 4'd1, 8'h00},  // R1
        {OP_C, KY, 4'd2, 8'h00},                                                     // R2
        {OP_W, CT, 4'd3, 8'hE1}, {OP_C, CT, 4'd3, 8'h01}, {OP_T, CT, 4'd3, 8'd1},    // R3
        {OP_C, CT, 4'd3, 8'h00}, {OP_C, DA, 4'd1, 8'hFF},
        {OP_W, CT, 4'd5, 8'h04}, {OP_W, AD, 4'd5, 8'h05}, {OP_W, DA, 4'd5, 8'h3C},   // R5 write
        {OP_W, KY, 4'd5, 8'h55}, {OP_W, KY, 4'd5, 8'hAA}, {OP_W, CT, 4'd5, 8'h06},
        {OP_C, CT, 4'd5, 8'h06}, {OP_T, CT, 4'd7, 8'd15}, {OP_C, CT, 4'd7, 8'h06},   // R7
        {OP_T, CT, 4'd7, 8'd1},  {OP_C, CT, 4'd8, 8'h14},                            // R8
        {OP_W, AD, 4'd3, 8'h45}, {OP_W, CT, 4'd3, 8'h15}, {OP_T, CT, 4'd3, 8'd1},
        {OP_C, DA, 4'd3, 8'h3C}, {OP_C, CT, 4'd8, 8'h14},
        {OP_W, CT, 4'd8, 8'h04}, {OP_C, CT, 4'd8, 8'h04},
        {OP_W, CT, 4'd5, 8'h06}, {OP_C, CT, 4'd5, 8'h04},                            // R5 no keys
        {OP_W, KY, 4'd5, 8'h55}, {OP_W, DA, 4'd5, 8'h77}, {OP_W, KY, 4'd5, 8'hAA},   // R5 broken
        {OP_W, CT, 4'd5, 8'h06}, {OP_C, CT, 4'd5, 8'h04},
        {OP_W, CT, 4'd5, 8'h05}, {OP_T, CT, 4'd5, 8'd1}, {OP_C, DA, 4'd5, 8'h3C},
        {OP_W, CT, 4'd6, 8'h00}, {OP_W, KY, 4'd6, 8'h55}, {OP_W, KY, 4'd6, 8'hAA},   // R6
        {OP_W, CT, 4'd6, 8'h06}, {OP_C, CT, 4'd6, 8'h04},
        {OP_W, CT, 4'd6, 8'h05}, {OP_T, CT, 4'd6, 8'd1}, {OP_C, DA, 4'd6, 8'h3C},
        {OP_W, KY, 4'd6, 8'h55}, {OP_W, KY, 4'd6, 8'hAA}, {OP_W, CT, 4'd6, 8'h02},
        {OP_C, CT, 4'd6, 8'h00},
        {OP_W, CT, 4'd4, 8'h04}, {OP_W, AD, 4'd4, 8'h09}, {OP_W, DA, 4'd4, 8'hA5},   // R4 / R10
        {OP_W, KY, 4'd4, 8'h55}, {OP_W, KY, 4'd4, 8'hAA}, {OP_W, CT, 4'd4, 8'h06},
        {OP_W, CT, 4'd4, 8'h05}, {OP_C, CT, 4'd4, 8'h06},
        {OP_W, AD, 4'd10, 8'h05}, {OP_W, DA, 4'd10, 8'h11}, {OP_C, DA, 4'd10, 8'h11},
        {OP_T, CT, 4'd8, 8'd13}, {OP_C, CT, 4'd8, 8'h14},
        {OP_W, AD, 4'd10, 8'h09}, {OP_W, CT, 4'd10, 8'h05}, {OP_T, CT, 4'd10, 8'd1},
        {OP_C, DA, 4'd10, 8'hA5},
        {OP_W, AD, 4'd10, 8'h05}, {OP_W, CT, 4'd10, 8'h05}, {OP_T, CT, 4'd10, 8'd1},
        {OP_C, DA, 4'd10, 8'h3C},
        {OP_W, CT, 4'd9, 8'h04}, {OP_W, AD, 4'd9, 8'h09}, {OP_W, DA, 4'd9, 8'h5A},   // R9 erase abort
        {OP_W, KY, 4'd9, 8'h55}, {OP_W, KY, 4'd9, 8'hAA}, {OP_W, CT, 4'd9, 8'h06},
        {OP_T, CT, 4'd9, 8'd3},  {OP_X, CT, 4'd9, 8'd0}, {OP_C, CT, 4'd9, 8'h08},
        {OP_W, CT, 4'd9, 8'h09}, {OP_T, CT, 4'd9, 8'd1}, {OP_C, DA, 4'd9, 8'hA5},
        {OP_W, CT, 4'd9, 8'h04}, {OP_C, CT, 4'd9, 8'h04},
        {OP_W, DA, 4'd9, 8'h5A}, {OP_W, KY, 4'd9, 8'h55}, {OP_W, KY, 4'd9, 8'hAA},   // R9 program abort
        {OP_W, CT, 4'd9, 8'h06}, {OP_T, CT, 4'd9, 8'd10}, {OP_X, CT, 4'd9, 8'd0},
        {OP_C, CT, 4'd9, 8'h08},
        {OP_W, CT, 4'd9, 8'h01}, {OP_T, CT, 4'd9, 8'd1}, {OP_C, DA, 4'd9, 8'hFF},
        {OP_C, CT, 4'd9, 8'h00},
        {OP_X, CT, 4'd11, 8'd0}, {OP_C, CT, 4'd11, 8'h00}, {OP_C, DA, 4'd11, 8'hFF}, // R11
        {OP_C, AD, 4'd11, 8'h09},
        {OP_W, AD, 4'd11, 8'h05}, {OP_W, CT, 4'd11, 8'h01}, {OP_T, CT, 4'd11, 8'd1},
        {OP_C, DA, 4'd11, 8'h3C}
    };

    logic       clk = 1'b0;
    logic       por_n, warm_n, bus_wr;
    logic [1:0] bus_sel;
    logic [7:0] bus_wdata, bus_rdata;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         ended = 1'b0;

    always #10 clk = ~clk;

    nvbyte_ctrl #(
        .DEPTH     (64),
        .ERASE_CYC (ERASE_CYC),
        .PROG_CYC  (PROG_CYC)
    ) dut (
        .clk       (clk),
        .por_n     (por_n),
        .warm_n    (warm_n),
        .bus_wr    (bus_wr),
        .bus_sel   (bus_sel),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    task automatic bwrite(input logic [1:0] s, input logic [7:0] d);
        bus_wr    = 1'b1;
        bus_sel   = s;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic check(input logic [1:0] s, input logic [7:0] exp, input int req);
        bus_sel = s;
        #1;
        n_chk++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL R%0d sel=%0d actual=%02h expected=%02h", req, s, bus_rdata, exp);
        end
    endtask

    task automatic warm_pulse();
        warm_n = 1'b0;
        @(negedge clk);
        warm_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        por_n     = 1'b0;
        warm_n    = 1'b1;
        bus_wr    = 1'b0;
        bus_sel   = 2'd0;
        bus_wdata = 8'h00;
        repeat (3) @(negedge clk);
        por_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            unique case (VEC[i][15:14])
                OP_W: bwrite(VEC[i][13:12], VEC[i][7:0]);
                OP_C: check(VEC[i][13:12], VEC[i][7:0], int'(VEC[i][11:8]));
                OP_T: repeat (int'(VEC[i][7:0])) @(negedge clk);
                OP_X: warm_pulse();
                default: ;
            endcase
        end

        // Directed: power-on reset after activity restores R1 state.
        por_n = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        check(CT, 8'h00, 1);  // R1
        check(DA, 8'h00, 1);  // R1
        check(AD, 8'h00, 1);  // R1
        bwrite(AD, 8'h05);
        bwrite(CT, 8'h01);
        @(negedge clk);
        check(DA, 8'hFF, 1);  // R1 store re-erased

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

endmodule